// File: doc/BRIEF.md
# SDRAM Read Data Latency Pipeline

This block is the output side of a synchronous DRAM read path. For each read beat the core raises a read strobe together with the word it fetched from the array. The block holds that word for a programmable number of clocks, 2 or 3, and then drives it onto a 16-bit data output with a valid flag. Each byte of the output has its own enable. A byte mask input turns that enable off two clocks after the mask is sampled, whatever latency is in use.

A burst-stop or precharge command cancels the beat captured on the same edge. Beats captured earlier still drain. As a result the bus goes idle a number of clocks equal to the selected latency after the command. The latency setting is held in a small mode register that is loaded by a strobe. Every strobed beat stands alone, so a new read can follow on the very next cycle and takes over from the burst in progress.

Top module: `sdram_rd_pipe`

## Requirements
- R1: While rst_ni is low and after its release, dq_vld_o and dq_oe_o are 0, dq_o is 0, and the latency setting is 3.
- R2: When mode_ld_i is high at a rising edge, the latency setting becomes 3 if mode_lat3_i is 1 and 2 if it is 0. Without mode_ld_i the setting holds. A new setting takes effect on the output from the cycle after that edge.
- R3: At latency 2, a beat captured at edge k (rd_i high, bstop_i and pre_i low) appears on dq_o with dq_vld_o high in the cycle after edge k+1, so it is sampled at edge k+2.
- R4: At latency 3, that beat appears in the cycle after edge k+2 and is sampled at edge k+3.
- R5: Reads on consecutive cycles give consecutive output words in capture order, one per cycle, with no gap and no repeat.
- R6: dq_oe_o[1] enables dq_o[15:8] and dq_oe_o[0] enables dq_o[7:0]. dq_oe_o[b] is high exactly when dq_vld_o is high and dqm_i[b], sampled two edges earlier, was low. The mask delay does not depend on the latency setting.
- R7: bstop_i or pre_i high at edge p discards the beat captured at p, even when rd_i is also high. The output is idle in the cycle after edge p+L-1, where L is the latency. Beats captured before p still come out.
- R8: Whenever dq_vld_o is low, dq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_ld_i | input | 1 | Load strobe for the latency setting |
| mode_lat3_i | input | 1 | Latency to load: 1 selects 3, 0 selects 2 |
| rd_i | input | 1 | Read beat strobe |
| rd_data_i | input | 16 | Word fetched from the array for this beat |
| dqm_i | input | 2 | Byte masks: bit 1 upper byte, bit 0 lower byte |
| bstop_i | input | 1 | Burst-stop command |
| pre_i | input | 1 | Precharge command |
| dq_o | output | 16 | Output data word |
| dq_vld_o | output | 1 | Output word valid |
| dq_oe_o | output | 2 | Per-byte output drive enable |

## Verification
The assertions check the following on every cycle:
- the delay from a captured beat to valid data at each latency, with the word itself compared against its value at capture;
- the two-clock mask-to-disable path on each byte;
- the idle output that follows a burst-stop or precharge.

Some behaviours need the bench's scenarios to show them: the reset value of the latency setting, and the moment a changed setting reaches the output. The bench also covers unbroken back-to-back streams, zero data on an idle bus, and the case of a read and a stop on the same edge. It checks these against a cycle-accurate history model under random traffic that includes latency reloads in mid-stream.

// File: rtl/sdram_rd_pipe_pkg.sv
package sdram_rd_pipe_pkg;
  typedef enum logic {
    LAT2 = 1'b0,
    LAT3 = 1'b1
  } cas_lat_e;
endpackage

// File: rtl/rdp_mode_reg.sv
module rdp_mode_reg
  import sdram_rd_pipe_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ld_i,
  input  logic     lat3_i,
  output cas_lat_e lat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lat_o <= LAT3;
    else if (ld_i) lat_o <= lat3_i ? LAT3 : LAT2;
  end
endmodule

// File: rtl/rdp_delay_line.sv
module rdp_delay_line #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [W-1:0]               d_i,
  output logic [DEPTH-1:0][W-1:0]    tap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tap_o[0] <= '0;
    else         tap_o[0] <= d_i;
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tap_o[s] <= '0;
      else         tap_o[s] <= tap_o[s-1];
    end
  end
endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe
  import sdram_rd_pipe_pkg::*;
#(
  parameter int unsigned DW         = 16,
  parameter int unsigned NB         = 2,
  parameter int unsigned PIPE_DEPTH = 3,
  parameter int unsigned MASK_LAT   = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_ld_i,
  input  logic          mode_lat3_i,
  input  logic          rd_i,
  input  logic [DW-1:0] rd_data_i,
  input  logic [NB-1:0] dqm_i,
  input  logic          bstop_i,
  input  logic          pre_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_vld_o,
  output logic [NB-1:0] dq_oe_o
);
  localparam int unsigned LW      = DW + 1;
  localparam int unsigned BW      = DW / NB;
  localparam int unsigned TAP_SHT = PIPE_DEPTH - 2;
  localparam int unsigned TAP_LNG = PIPE_DEPTH - 1;

  cas_lat_e lat_q;
  logic     kill;
  logic [LW-1:0] beat_in, beat_sel;
  logic [PIPE_DEPTH-1:0][LW-1:0] beat_q;
  logic [MASK_LAT-1:0][NB-1:0]   mask_q;

  rdp_mode_reg u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (mode_ld_i),
    .lat3_i (mode_lat3_i),
    .lat_o  (lat_q)
  );

  // stop/precharge cancels the beat on the same edge; older beats drain
  assign kill    = bstop_i | pre_i;
  assign beat_in = (rd_i && !kill) ? {1'b1, rd_data_i} : '0;

  rdp_delay_line #(.W(LW), .DEPTH(PIPE_DEPTH)) u_beat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (beat_in),
    .tap_o  (beat_q)
  );

  rdp_delay_line #(.W(NB), .DEPTH(MASK_LAT)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (dqm_i),
    .tap_o  (mask_q)
  );

  assign beat_sel = (lat_q == LAT3) ? beat_q[TAP_LNG] : beat_q[TAP_SHT];
  assign dq_vld_o = beat_sel[LW-1];
  assign dq_o     = beat_sel[DW-1:0];

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign dq_oe_o[b] = dq_vld_o & ~mask_q[MASK_LAT-1][b];

    // R6
    mask_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(dqm_i[b], 2) |-> !dq_oe_o[b]);
  end

  // R3
  lat2_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q == LAT2 && $past(rst_ni, 2) && $past(rd_i && !bstop_i && !pre_i, 2))
    |-> (dq_vld_o && dq_o == $past(rd_data_i, 2)));

  // R4
  lat3_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q == LAT3 && $past(rst_ni, 3) && $past(rd_i && !bstop_i && !pre_i, 3))
    |-> (dq_vld_o && dq_o == $past(rd_data_i, 3)));

  // R7
  stop_lat2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q == LAT2 && $past(bstop_i || pre_i, 2)) |-> !dq_vld_o);

  // R7
  stop_lat3_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q == LAT3 && $past(bstop_i || pre_i, 3)) |-> !dq_vld_o);

  // R8
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_vld_o |-> (dq_o == '0));

  logic unused_bw;
  assign unused_bw = (BW == 0);
endmodule

// File: tb/sdram_rd_pipe_test.sv
module sdram_rd_pipe_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_ld_i = 1'b0, mode_lat3_i = 1'b0;
  logic        rd_i = 1'b0, bstop_i = 1'b0, pre_i = 1'b0;
  logic [15:0] rd_data_i = '0;
  logic [1:0]  dqm_i = '0;
  logic [15:0] dq_o;
  logic        dq_vld_o;
  logic [1:0]  dq_oe_o;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_tag = "";

  // history: index j = captured at edge c-j
  bit          h_rd[4];
  bit          h_kill[4];
  logic [15:0] h_data[4];
  logic [1:0]  h_dqm[4];
  int          lat_m = 3;

  sdram_rd_pipe uut (.*);

  always #10 clk_i = ~clk_i;

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_vld(int l);
    return h_rd[l-1] && !h_kill[l-1];
  endfunction

  task automatic check_outs();
    int  l = lat_m;
    bit  v = exp_vld(l);
    string t = (cur_tag != "") ? cur_tag : (h_kill[l-1] ? "R7" : (l == 2 ? "R3" : "R4"));
    chk(t, "vld", 32'(dq_vld_o), 32'(v));
    if (v) chk(t, "data", 32'(dq_o), 32'(h_data[l-1]));
    else   chk("R8", "idle data", 32'(dq_o), 32'h0);
    // R6: oe per byte from mask sampled two edges back
    chk("R6", "oe", 32'(dq_oe_o), 32'({2{v}} & ~h_dqm[1]));
  endtask

  task automatic step(bit rd, logic [15:0] d, logic [1:0] m, bit bs, bit pr, bit ld, bit l3);
    rd_i = rd; rd_data_i = d; dqm_i = m; bstop_i = bs; pre_i = pr;
    mode_ld_i = ld; mode_lat3_i = l3;
    @(posedge clk_i);
    for (int j = 3; j > 0; j--) begin
      h_rd[j] = h_rd[j-1]; h_kill[j] = h_kill[j-1];
      h_data[j] = h_data[j-1]; h_dqm[j] = h_dqm[j-1];
    end
    h_rd[0] = rd; h_kill[0] = bs | pr; h_data[0] = d; h_dqm[0] = m;
    if (ld) lat_m = l3 ? 3 : 2;
    @(negedge clk_i);
    check_outs();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, '0, '0, 0, 0, 0, 0);
  endtask

  initial begin
    int seq;
    void'($urandom(32'd4242));
    for (int j = 0; j < 4; j++) begin
      h_rd[j] = 0; h_kill[j] = 0; h_data[j] = '0; h_dqm[j] = '0;
    end
    repeat (3) @(negedge clk_i);
    // R1: outputs idle during reset
    chk("R1", "vld in reset", 32'(dq_vld_o), 0);
    chk("R1", "oe in reset", 32'(dq_oe_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "dq after reset", 32'(dq_o), 0);
    // R1: default latency 3 seen by a single beat
    cur_tag = "R1";
    step(1, 16'hA5C3, 2'b00, 0, 0, 0, 0);
    step(0, '0, '0, 0, 0, 0, 0);
    chk("R1", "not yet at lat3", 32'(dq_vld_o), 0);
    step(0, '0, '0, 0, 0, 0, 0);
    chk("R1", "lat3 default data", 32'(dq_o), 32'hA5C3);
    idle(3);

    // R2: load latency 2, beat appears one cycle earlier
    cur_tag = "R2";
    step(0, '0, '0, 0, 0, 1, 0);
    step(1, 16'h1234, 2'b00, 0, 0, 0, 0);
    step(0, '0, '0, 0, 0, 0, 0);
    chk("R2", "lat2 after load", 32'(dq_o), 32'h1234);
    idle(3);

    // R5: back-to-back stream at latency 2 then 3
    cur_tag = "R5";
    for (int i = 0; i < 8; i++) step(1, 16'(16'h0100 + i), 2'b00, 0, 0, 0, 0);
    idle(3);
    step(0, '0, '0, 0, 0, 1, 1);
    for (int i = 0; i < 8; i++) step(1, 16'(16'h0200 + i), 2'b00, 0, 0, 0, 0);
    idle(4);

    // R6: mask pulses on each byte, and with no read
    cur_tag = "";
    step(1, 16'hBEEF, 2'b10, 0, 0, 0, 0);
    step(1, 16'hCAFE, 2'b01, 0, 0, 0, 0);
    step(0, '0, 2'b11, 0, 0, 0, 0);
    idle(4);

    // R7: stop mid-burst and read coinciding with precharge
    cur_tag = "R7";
    step(1, 16'h0A01, 2'b00, 0, 0, 0, 0);
    step(1, 16'h0A02, 2'b00, 0, 0, 0, 0);
    step(1, 16'h0A03, 2'b00, 1, 0, 0, 0);
    step(1, 16'h0A04, 2'b00, 0, 1, 0, 0);
    idle(4);
    step(0, '0, '0, 0, 0, 1, 0);
    step(1, 16'h0B01, 2'b00, 0, 0, 0, 0);
    step(1, 16'h0B02, 2'b00, 0, 1, 0, 0);
    idle(4);
    cur_tag = "";

    // random traffic with occasional latency reloads
    for (int i = 0; i < 4000; i++) begin
      seq = $urandom;
      step(seq[2:0] < 5, 16'($urandom), {seq[5:4] == 0, seq[7:6] == 0},
           seq[12:8] == 0, seq[17:13] == 0, seq[23:18] == 0, seq[24]);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule